// File: doc/BRIEF.md
# Memory PHY Latency-Aligned Valid Generator

This block sits between a DDR memory controller and its PHY and turns command-side pulses into data-side strobes, using latencies that calibration has already measured. A read-issue pulse is delayed by the read latency to form a read-data-valid indication. A write-command pulse is delayed by the write latency to raise the DQS-burst enable. Both delays are counted in controller-clock cycles.

The latency values and the rate mode are sampled once, on the cycle where the calibration-done flag rises. They then stay fixed, whatever happens on the latency inputs. In half-rate mode the read-valid output is a two-bit vector with one bit per half-rate phase. A phase select that travels with each read marks whether the returned word is aligned. In full-rate mode only the low bit is used.

Each delay is a tapped shift register. Reads or writes issued on every cycle therefore each produce their own delayed strobe. While calibration is not done, both outputs stay low.

Top module: `memlat_valid_gen`

## Requirements
- R1: With a captured read latency L from 1 to 32, a read-issue pulse high in cycle n makes `rd_valid` non-zero in cycle n+L and in no other cycle. A latency of 9 gives valid data 9 cycles after the pulse.
- R2: With a captured write latency W from 1 to 32, a `wr_cmd` pulse high in cycle n makes `dqs_burst` high in cycle n+W and in no other cycle.
- R3: `rd_lat_in`, `wr_lat_in` and `half_rate` are captured on the clock edge where `cal_done` is first seen high. Later changes to these inputs have no effect on output timing or on the valid pattern.
- R4: While `cal_done` is low, `rd_valid` is 2'b00 and `dqs_burst` is 0. Pulses issued while `cal_done` is low never produce an output later.
- R5: In half-rate mode (`half_rate`=1 at capture), a read issued with `rd_phase`=0 shows as `rd_valid`=2'b10, and one issued with `rd_phase`=1 shows as 2'b01. The two bits are never high together.
- R6: In full-rate mode (`half_rate`=0 at capture), a delayed read shows as `rd_valid`=2'b01 whatever `rd_phase` was, and bit 1 stays 0.
- R7: A captured latency of 0 passes the pulse through combinationally, in the same cycle.
- R8: A latency input larger than 32 acts as a latency of 32.
- R9: Pulses on consecutive cycles produce an equal number of consecutive output cycles, each shifted by the latency.
- R10: Synchronous active-high `rst` clears the delay stages, the captured settings and the calibration edge detector. A pulse in flight at reset never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_done | input | 1 | Calibration complete; its rising edge captures the settings |
| rd_lat_in | input | 6 | Read latency in controller cycles |
| wr_lat_in | input | 6 | Write latency in controller cycles |
| half_rate | input | 1 | 1 selects half-rate mode, 0 selects full-rate mode |
| rd_issue | input | 1 | Read-issue pulse |
| rd_phase | input | 1 | Phase of the returned read word, sampled with `rd_issue` |
| wr_cmd | input | 1 | Write-command pulse |
| rd_valid | output | 2 | Read-data-valid phase vector |
| dqs_burst | output | 1 | DQS-burst enable |

## Verification
The assertions assume that `rd_phase` is only meaningful alongside `rd_issue`. They also assume that the latency and rate inputs matter only on the `cal_done` edge, and that `cal_done` stays high between a pulse and the one-cycle check that follows it. The unit-latency and zero-latency properties accept a low output only when `cal_done` has dropped.

The bench changes inputs just after the falling clock edge and samples 1 ns later, so combinational pass-through and registered outputs are both read in settled form. It keeps `cal_done` steady across each measurement window, except in the directed case that drops it on purpose.

// File: rtl/memlat_pkg.sv
package memlat_pkg;

    localparam int DLY_DEPTH = 32;
    localparam int LAT_W     = 6;

    typedef logic [LAT_W-1:0] lat_t;

    typedef enum logic {
        RATE_FULL = 1'b0,
        RATE_HALF = 1'b1
    } rate_e;

    typedef struct packed {
        lat_t  rd_lat;
        lat_t  wr_lat;
        rate_e rate;
    } lat_cfg_t;

    // token carried through the read delay line
    typedef struct packed {
        logic phase;
        logic hit;
    } rd_tok_t;

    function automatic lat_t clamp_lat(input lat_t v, input int depth);
        if (int'(v) > depth)
            return lat_t'(depth);
        return v;
    endfunction

endpackage

// File: rtl/memlat_cfg_capture.sv
module memlat_cfg_capture
    import memlat_pkg::*;
#(
    parameter int DEPTH = DLY_DEPTH
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cal_done,
    input  lat_t     rd_lat_in,
    input  lat_t     wr_lat_in,
    input  logic     half_rate,
    output lat_cfg_t cfg,
    output logic     armed
);

    logic cal_q;
    logic cal_rise;

    assign cal_rise = cal_done && !cal_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q <= 1'b0;
            cfg   <= '0;
        end else begin
            cal_q <= cal_done;
            if (cal_rise) begin
                cfg.rd_lat <= clamp_lat(rd_lat_in, DEPTH);
                cfg.wr_lat <= clamp_lat(wr_lat_in, DEPTH);
                cfg.rate   <= half_rate ? RATE_HALF : RATE_FULL;
            end
        end
    end

    // settings are valid only once the capture edge has passed
    assign armed = cal_done && cal_q;

endmodule

// File: rtl/memlat_pulse_delay.sv
module memlat_pulse_delay #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 32,
    parameter int LW    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LW-1:0]    lat,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][WIDTH-1:0] stg;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg[0] <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[DEPTH-2:0], din};
            end
        end
    endgenerate

    always_comb begin
        if (lat == '0)
            dout = din;
        else if (int'(lat) > DEPTH)
            dout = stg[DEPTH-1];
        else
            dout = stg[IDX_W'(lat - LW'(1))];
    end

endmodule

// File: rtl/memlat_rd_shaper.sv
module memlat_rd_shaper
    import memlat_pkg::*;
(
    input  rd_tok_t    tok,
    input  rate_e      rate,
    output logic [1:0] vld
);

    always_comb begin
        if (!tok.hit)
            vld = 2'b00;
        else if (rate == RATE_FULL)
            vld = 2'b01;
        else
            vld = tok.phase ? 2'b01 : 2'b10;
    end

endmodule

// File: rtl/memlat_valid_gen.sv
module memlat_valid_gen
    import memlat_pkg::*;
#(
    parameter int DEPTH = DLY_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cal_done,
    input  logic [LAT_W-1:0] rd_lat_in,
    input  logic [LAT_W-1:0] wr_lat_in,
    input  logic             half_rate,
    input  logic             rd_issue,
    input  logic             rd_phase,
    input  logic             wr_cmd,
    output logic [1:0]       rd_valid,
    output logic             dqs_burst
);

    lat_cfg_t cfg;
    logic     armed;
    lat_t     lat_rd;
    lat_t     lat_wr;
    rate_e    rate_q;
    rd_tok_t  rd_in;
    rd_tok_t  rd_out;
    logic     wr_in;
    logic     wr_out;
    logic [1:0] rd_shaped;

    memlat_cfg_capture #(.DEPTH(DEPTH)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .cal_done  (cal_done),
        .rd_lat_in (rd_lat_in),
        .wr_lat_in (wr_lat_in),
        .half_rate (half_rate),
        .cfg       (cfg),
        .armed     (armed)
    );

    assign lat_rd = cfg.rd_lat;
    assign lat_wr = cfg.wr_lat;
    assign rate_q = cfg.rate;

    // pulses before calibration never enter the delay lines
    assign rd_in.hit   = rd_issue && armed;
    assign rd_in.phase = rd_phase && armed;
    assign wr_in       = wr_cmd && armed;

    memlat_pulse_delay #(.WIDTH(2), .DEPTH(DEPTH), .LW(LAT_W)) u_rd_dly (
        .clk  (clk),
        .rst  (rst),
        .lat  (lat_rd),
        .din  (rd_in),
        .dout (rd_out)
    );

    memlat_pulse_delay #(.WIDTH(1), .DEPTH(DEPTH), .LW(LAT_W)) u_wr_dly (
        .clk  (clk),
        .rst  (rst),
        .lat  (lat_wr),
        .din  (wr_in),
        .dout (wr_out)
    );

    memlat_rd_shaper u_shape (
        .tok  (rd_out),
        .rate (rate_q),
        .vld  (rd_shaped)
    );

    assign rd_valid  = armed ? rd_shaped : 2'b00;
    assign dqs_burst = armed && wr_out;

endmodule

// File: rtl/memlat_valid_gen_chk.sv
module memlat_valid_gen_chk
    import memlat_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cal_done,
    input logic       rd_issue,
    input logic       wr_cmd,
    input logic [1:0] rd_valid,
    input logic       dqs_burst,
    input logic       armed,
    input lat_t       lat_rd,
    input lat_t       lat_wr,
    input rate_e      rate_q
);

    a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
        !cal_done |-> (rd_valid == 2'b00 && !dqs_burst));

    a_r5_one_phase: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_valid));

    a_r6_full_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (armed && rate_q == RATE_FULL) |-> !rd_valid[1]);

    a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(armed)) |-> ($stable(lat_rd) && $stable(lat_wr) && $stable(rate_q)));

    a_r1_unit_lat: assert property (@(posedge clk) disable iff (rst)
        (armed && lat_rd == lat_t'(1) && rd_issue) |=> (!cal_done || rd_valid != 2'b00));

    a_r2_unit_lat: assert property (@(posedge clk) disable iff (rst)
        (armed && lat_wr == lat_t'(1) && wr_cmd) |=> (!cal_done || dqs_burst));

    a_r7_zero_lat: assert property (@(posedge clk) disable iff (rst)
        (armed && lat_rd == '0 && rd_issue) |-> (rd_valid != 2'b00));

endmodule

bind memlat_valid_gen memlat_valid_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cal_done  (cal_done),
    .rd_issue  (rd_issue),
    .wr_cmd    (wr_cmd),
    .rd_valid  (rd_valid),
    .dqs_burst (dqs_burst),
    .armed     (armed),
    .lat_rd    (lat_rd),
    .lat_wr    (lat_wr),
    .rate_q    (rate_q)
);

// File: tb/tb_memlat_valid_gen.sv
`timescale 1ns/1ps
module tb_memlat_valid_gen;

    localparam int DEPTH = 32;
    localparam int NV    = 8;
    localparam int WIN   = 45;

    // {read lat in, write lat in, half_rate, rd_phase}
    localparam int VEC [NV][4] = '{
        '{9, 5, 0, 0},
        '{9, 5, 1, 0},
        '{9, 5, 1, 1},
        '{0, 0, 0, 1},
        '{1, 1, 1, 0},
        '{32, 31, 0, 0},
        '{40, 50, 1, 1},
        '{3, 7, 0, 1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cal_done = 1'b0;
    logic [5:0] rd_lat_in = '0;
    logic [5:0] wr_lat_in = '0;
    logic       half_rate = 1'b0;
    logic       rd_issue = 1'b0;
    logic       rd_phase = 1'b0;
    logic       wr_cmd = 1'b0;
    logic [1:0] rd_valid;
    logic       dqs_burst;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    memlat_valid_gen #(.DEPTH(DEPTH)) dut (
        .clk       (clk),
        .rst       (rst),
        .cal_done  (cal_done),
        .rd_lat_in (rd_lat_in),
        .wr_lat_in (wr_lat_in),
        .half_rate (half_rate),
        .rd_issue  (rd_issue),
        .rd_phase  (rd_phase),
        .wr_cmd    (wr_cmd),
        .rd_valid  (rd_valid),
        .dqs_burst (dqs_burst)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cal_done = 1'b0;
        rd_issue = 1'b0;
        wr_cmd = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic calibrate(input int rl, input int wl, input bit hr);
        rd_lat_in = 6'(rl);
        wr_lat_in = 6'(wl);
        half_rate = hr;
        cal_done  = 1'b1;
        @(negedge clk);
    endtask

    // pulses in cycles 0..n-1; expects outputs in cycles re..re+n-1 / we..we+n-1
    task automatic run(input int re, input int we, input logic [1:0] pat,
                       input bit ph, input int n, input string tag);
        bit rbad = 0, wbad = 0;
        int ract = 0, wact = 0, rexp = 0, wexp = 0, rcyc = 0, wcyc = 0;
        for (int j = 0; j < WIN; j++) begin
            logic [1:0] er;
            logic       ew;
            rd_issue = (j < n);
            wr_cmd   = (j < n);
            rd_phase = ph;
            #1;
            er = (j >= re && j < re + n) ? pat : 2'b00;
            ew = (j >= we && j < we + n);
            if (!rbad && rd_valid !== er) begin
                rbad = 1; ract = int'(rd_valid); rexp = int'(er); rcyc = j;
            end
            if (!wbad && dqs_burst !== ew) begin
                wbad = 1; wact = int'(dqs_burst); wexp = int'(ew); wcyc = j;
            end
            @(negedge clk);
        end
        rd_issue = 1'b0;
        wr_cmd = 1'b0;
        if (rbad) $display("  read mismatch at cycle %0d (%s)", rcyc, tag);
        chk(!rbad, {tag, " rd_valid"}, ract, rexp);
        if (wbad) $display("  write mismatch at cycle %0d (%s)", wcyc, tag);
        chk(!wbad, {tag, " dqs_burst"}, wact, wexp);
    endtask

    initial begin
        #1000000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R10 reset state
        #1;
        chk(rd_valid === 2'b00 && dqs_burst === 1'b0, "R10 reset outputs low",
            int'({rd_valid, dqs_burst}), 0);
        @(negedge clk);

        // vector table: R1 R2 plus mode / corner tags
        for (int v = 0; v < NV; v++) begin
            int re, we;
            logic [1:0] pat;
            string tag;
            re = (VEC[v][0] > DEPTH) ? DEPTH : VEC[v][0];
            we = (VEC[v][1] > DEPTH) ? DEPTH : VEC[v][1];
            if (VEC[v][2] == 1) pat = (VEC[v][3] == 1) ? 2'b01 : 2'b10;
            else                pat = 2'b01;
            tag = (VEC[v][2] == 1) ? "R1 R2 R5" : "R1 R2 R6";
            if (VEC[v][0] == 0) tag = {tag, " R7"};
            if (VEC[v][0] > DEPTH) tag = {tag, " R8"};
            do_reset();
            calibrate(VEC[v][0], VEC[v][1], VEC[v][2] == 1);
            run(re, we, pat, VEC[v][3] == 1, 1, tag);
        end

        // R4: pulses before calibration leave nothing behind
        begin
            bit bad = 0;
            do_reset();
            rd_lat_in = 6'd3; wr_lat_in = 6'd3;
            for (int j = 0; j < 10; j++) begin
                rd_issue = 1'b1; wr_cmd = 1'b1;
                #1;
                if (rd_valid !== 2'b00 || dqs_burst !== 1'b0) bad = 1;
                @(negedge clk);
            end
            rd_issue = 1'b0; wr_cmd = 1'b0;
            chk(!bad, "R4 outputs low before cal", int'(bad), 0);
            calibrate(3, 3, 0);
            run(0, 0, 2'b01, 0, 0, "R4 no stale pulses");
        end

        // R3: inputs changed after capture are ignored
        do_reset();
        calibrate(4, 2, 1);
        rd_lat_in = 6'd10; wr_lat_in = 6'd10; half_rate = 1'b0;
        run(4, 2, 2'b01, 1, 1, "R3 frozen settings");

        // R9: pulses on four consecutive cycles
        do_reset();
        calibrate(5, 2, 1);
        run(5, 2, 2'b10, 0, 4, "R9 back-to-back");

        // R10: reset drops an in-flight pulse
        do_reset();
        calibrate(6, 6, 0);
        rd_issue = 1'b1; wr_cmd = 1'b1;
        @(negedge clk);
        rd_issue = 1'b0; wr_cmd = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        run(0, 0, 2'b01, 0, 0, "R10 in-flight cleared");

        // R4: dropping cal_done forces outputs low
        begin
            bit bad = 0;
            do_reset();
            calibrate(3, 3, 0);
            rd_issue = 1'b1; wr_cmd = 1'b1;
            @(negedge clk);
            rd_issue = 1'b0; wr_cmd = 1'b0;
            cal_done = 1'b0;
            for (int j = 1; j < 8; j++) begin
                #1;
                if (rd_valid !== 2'b00 || dqs_burst !== 1'b0) bad = 1;
                @(negedge clk);
            end
            chk(!bad, "R4 outputs low after cal_done drops", int'(bad), 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule